// File: doc/BRIEF.md
# Delayed Write Completion Unit

This unit sits at the head of a bridge's delayed-write queue. It holds one buffered write: address, command, data and byte enables. It also holds the completion status that comes back from the far side of the bridge, including a flag that says whether the far side reported a parity error. It watches a simplified bus with a single data phase per transfer. When the original initiator repeats its write, the unit decides whether the repeat is the same transaction. If it is, the unit completes it. If it is not, the unit tells the initiator to retry. The unit also drives the parity error strobe and keeps a sticky parity-error-detected flag.

The comparison uses address, command, data and byte enables only; the parity bit is left out. Parity is even over the 32 data bits, the 4 byte-enable bits and the parity bit. The parity bit arrives one cycle after the data phase it covers, and the unit decides on that cycle. If parity is bad on a matching repeat, the data phase is still acknowledged. The status is withheld and the entry stays at the head, so a later clean repeat can still finish it. If the far side had reported a parity error and the repeat is clean, the transfer completes normally and the error is echoed on the strobe.

Entries come in through a valid/ready port. An entry is taken on a clock edge where both `ld_valid` and `ld_ready` are high. `ld_ready` stays low from the edge that takes an entry until the cycle after the entry has been completed and removed. While it is low, `ld_valid` may be held high and the fields must stay stable. The status input and the bus pins are plain, with no handshake. All bus strobes are active low.

Top module: `dwc_completer`

## Requirements
- R1: `ld_ready` is high exactly when no entry is held. An entry is taken on an edge with `ld_valid` and `ld_ready` both high. `ld_ready` falls in the next cycle.
- R2: A data phase (`req_valid` high in cycle T) is answered with `stop_n` low and `trdy_n` high in cycle T+1 in three cases: no entry is held, no status has been captured for the entry, or the fields do not match. The entry is kept in all three cases.
- R3: A match needs `req_addr`, `req_cmd`, `req_data` and `req_be` all equal to the stored values. `req_par` takes no part in the match.
- R4: A matching data phase in cycle T gets `trdy_n` low and `stop_n` high for exactly cycle T+1. `trdy_n` and `stop_n` are never low together.
- R5: `req_par` is sampled in cycle T+1. A local parity error exists when the XOR of `req_data`, `req_be` (both from cycle T) and `req_par` is 1.
- R6: After an acknowledged phase with a local parity error, `done` stays low and the entry stays held. A later clean matching phase completes it.
- R7: A local parity error drives `perr_n` low for exactly cycle T+3 (two cycles after the `trdy_n` cycle), and only if `pe_resp_pri` is high in cycle T+1.
- R8: A local parity error sets `perr_det` from cycle T+2 on, whatever the enables are. A `perr_det_clr` pulse clears it the next cycle. A set in the same cycle as a clear wins.
- R9: When the stored status flags a far-side parity error and the phase is clean, the transfer completes with `done_tperr` high. `perr_n` goes low for exactly cycle T+3 only if both `pe_resp_pri` and `pe_resp_sec` are high in cycle T+1.
- R10: A clean matching phase gives a one-cycle `done` pulse in cycle T+2 and removes the entry. `done_tperr` carries the stored far-side flag in that cycle and is low whenever `done` is low.
- R11: While an acknowledged phase waits for its parity (cycle T+1), a new data phase is answered with a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Entry offered on the load port |
| ld_ready | output | 1 | Unit can take an entry |
| ld_addr | input | 32 | Entry address |
| ld_cmd | input | 4 | Entry command |
| ld_data | input | 32 | Entry write data |
| ld_be | input | 4 | Entry byte enables |
| sts_valid | input | 1 | Far-side completion status present |
| sts_tperr | input | 1 | Far side reported a parity error |
| req_valid | input | 1 | Initiator data phase present |
| req_addr | input | 32 | Data phase address |
| req_cmd | input | 4 | Data phase command |
| req_data | input | 32 | Data phase data |
| req_be | input | 4 | Data phase byte enables |
| req_par | input | 1 | Even parity, valid the cycle after the data phase |
| pe_resp_pri | input | 1 | Initiator-side parity response enable |
| pe_resp_sec | input | 1 | Far-side parity response enable |
| perr_det_clr | input | 1 | Write-one-to-clear pulse for `perr_det` |
| trdy_n | output | 1 | Data phase acknowledge, active low |
| stop_n | output | 1 | Retry, active low |
| perr_n | output | 1 | Parity error strobe, active low |
| done | output | 1 | Entry completed and removed |
| done_tperr | output | 1 | Far-side error flag of the completed entry |
| perr_det | output | 1 | Sticky parity-error-detected flag |

## Verification
The bench uses the default widths: 32-bit address and data, 4-bit command and byte enables, and a parity strobe delay of two. With these values every single-field mismatch can be produced, and the exact T+3 strobe cycle can be checked against the acknowledge cycle. A behavioural model drives the same stimulus, covering local errors with the enable on and off and all four enable combinations for forwarded errors. It also covers clean repeats after an error, a data phase that arrives during the parity wait, and a clear that lands on the same cycle as a set.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } dwc_entry_t;
endpackage

// File: rtl/dwc_parity_chk.sv
module dwc_parity_chk #(
  parameter int W = 36
) (
  input  logic [W-1:0] vec,
  input  logic         par,
  output logic         err
);
  // even parity: total ones over vec and par must be even
  always_comb err = (^vec) ^ par;
endmodule

// File: rtl/dwc_perr_delay.sv
module dwc_perr_delay #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  output logic perr_n
);
  localparam int STAGES = (DLY < 1) ? 1 : DLY;
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= ev;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], ev};
    end
  endgenerate

  assign perr_n = ~sh[STAGES-1];
endmodule

// File: rtl/dwc_head_store.sv
module dwc_head_store
  import dwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  dwc_entry_t ld_entry,
  input  logic       sts_valid,
  input  logic       sts_tperr,
  input  logic       pop,
  output dwc_entry_t head,
  output logic       head_valid,
  output logic       have_sts,
  output logic       tperr
);
  logic take;
  assign ld_ready = ~head_valid;
  assign take     = ld_valid & ld_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_valid <= 1'b0;
      have_sts   <= 1'b0;
      tperr      <= 1'b0;
      head       <= '0;
    end else if (pop) begin
      head_valid <= 1'b0;
      have_sts   <= 1'b0;
      tperr      <= 1'b0;
    end else begin
      if (take) begin
        head_valid <= 1'b1;
        head       <= ld_entry;
      end
      if (head_valid && !have_sts && sts_valid) begin
        have_sts <= 1'b1;
        tperr    <= sts_tperr;
      end
    end
  end

  // R1
  ld_take_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ld_ready);
  // R10
  pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (head_valid && have_sts));
endmodule

// File: rtl/dwc_completer.sv
module dwc_completer
  import dwc_pkg::*;
#(
  parameter int PERR_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CMD_W-1:0]  ld_cmd,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [BE_W-1:0]   ld_be,
  input  logic              sts_valid,
  input  logic              sts_tperr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_par,
  input  logic              pe_resp_pri,
  input  logic              pe_resp_sec,
  input  logic              perr_det_clr,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              perr_n,
  output logic              done,
  output logic              done_tperr,
  output logic              perr_det
);
  localparam int PV_W = DATA_W + BE_W;

  dwc_entry_t ld_entry, head, req_entry;
  logic head_valid, have_sts, tperr, pop;
  logic hit, ph_pend, par_err, perr_ev, set_det;
  logic [DATA_W-1:0] ph_data;
  logic [BE_W-1:0]   ph_be;

  assign ld_entry  = '{addr: ld_addr, cmd: ld_cmd, data: ld_data, be: ld_be};
  assign req_entry = '{addr: req_addr, cmd: req_cmd, data: req_data, be: req_be};

  dwc_head_store u_store (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_entry(ld_entry), .sts_valid(sts_valid), .sts_tperr(sts_tperr),
    .pop(pop), .head(head), .head_valid(head_valid), .have_sts(have_sts),
    .tperr(tperr)
  );

  // match ignores parity; one phase in flight at a time
  always_comb hit = req_valid && head_valid && have_sts && !ph_pend
                    && (req_entry == head);

  dwc_parity_chk #(.W(PV_W)) u_par (
    .vec({ph_data, ph_be}), .par(req_par), .err(par_err)
  );

  always_comb begin
    pop     = ph_pend && !par_err;
    set_det = ph_pend && par_err;
    perr_ev = ph_pend && pe_resp_pri && (par_err || (tperr && pe_resp_sec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trdy_n     <= 1'b1;
      stop_n     <= 1'b1;
      ph_pend    <= 1'b0;
      ph_data    <= '0;
      ph_be      <= '0;
      done       <= 1'b0;
      done_tperr <= 1'b0;
      perr_det   <= 1'b0;
    end else begin
      trdy_n     <= ~hit;
      stop_n     <= ~(req_valid && !hit);
      ph_pend    <= hit;
      if (hit) begin
        ph_data <= req_data;
        ph_be   <= req_be;
      end
      done       <= pop;
      done_tperr <= pop && tperr;
      if (set_det)           perr_det <= 1'b1;
      else if (perr_det_clr) perr_det <= 1'b0;
    end
  end

  dwc_perr_delay #(.DLY(PERR_DLY)) u_perr (
    .clk(clk), .rst_n(rst_n), .ev(perr_ev), .perr_n(perr_n)
  );

  // R4
  trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));
  // R10
  done_after_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!trdy_n));
  // R7
  perr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_n);
  // R8
  det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_det && !perr_det_clr) |=> perr_det);
  // R10
  done_tperr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_tperr |-> done);
endmodule

// File: tb/dwc_completer_test.sv
module dwc_completer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, sts_valid = 0, sts_tperr = 0, req_valid = 0, req_par = 0;
  logic pe_resp_pri = 0, pe_resp_sec = 0, perr_det_clr = 0;
  logic [31:0] ld_addr = 0, ld_data = 0, req_addr = 0, req_data = 0;
  logic [3:0]  ld_cmd = 0, ld_be = 0, req_cmd = 0, req_be = 0;
  logic ld_ready, trdy_n, stop_n, perr_n, done, done_tperr, perr_det;

  int checks = 0, failures = 0, ncyc = 0;
  int done_seen = 0, perr_seen = 0, stop_seen = 0, trdy_seen = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwc_completer uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_cmd(ld_cmd), .ld_data(ld_data), .ld_be(ld_be),
    .sts_valid(sts_valid), .sts_tperr(sts_tperr), .req_valid(req_valid),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_data(req_data),
    .req_be(req_be), .req_par(req_par), .pe_resp_pri(pe_resp_pri),
    .pe_resp_sec(pe_resp_sec), .perr_det_clr(perr_det_clr),
    .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n), .done(done),
    .done_tperr(done_tperr), .perr_det(perr_det)
  );

  // behavioural reference model
  bit m_head, m_sts, m_tperr, m_pend, m_det;
  logic [31:0] m_addr, m_data, m_pdata;
  logic [3:0]  m_cmd, m_be, m_pbe;
  bit sched[8];
  bit e_trdy, e_stop, e_done, e_dtp, e_perr;
  int cyc = 0;

  always @(posedge clk) begin
    bit hit, pop, set, ld_acc, lerr;
    if (!rst_n) begin
      m_head = 0; m_sts = 0; m_tperr = 0; m_pend = 0; m_det = 0;
      e_trdy = 0; e_stop = 0; e_done = 0; e_dtp = 0; e_perr = 0;
      foreach (sched[i]) sched[i] = 0;
    end else begin
      cyc++;
      e_perr = sched[cyc % 8]; sched[cyc % 8] = 0;
      hit = req_valid && m_head && m_sts && !m_pend && req_addr == m_addr
            && req_cmd == m_cmd && req_data == m_data && req_be == m_be;
      ld_acc = ld_valid && !m_head;
      pop = 0; set = 0; e_done = 0; e_dtp = 0;
      if (m_pend) begin
        lerr = (^m_pdata) ^ (^m_pbe) ^ req_par;
        if (lerr) begin
          set = 1;
          if (pe_resp_pri) sched[(cyc + 1) % 8] = 1;
        end else begin
          pop = 1; e_done = 1; e_dtp = m_tperr;
          if (m_tperr && pe_resp_pri && pe_resp_sec) sched[(cyc + 1) % 8] = 1;
        end
      end
      e_trdy = hit; e_stop = req_valid && !hit;
      m_pend = hit; m_pdata = req_data; m_pbe = req_be;
      if (set) m_det = 1; else if (perr_det_clr) m_det = 0;
      if (pop) begin m_head = 0; m_sts = 0; m_tperr = 0; end
      else if (sts_valid && m_head && !m_sts) begin m_sts = 1; m_tperr = sts_tperr; end
      if (ld_acc) begin
        m_head = 1; m_addr = ld_addr; m_cmd = ld_cmd; m_data = ld_data; m_be = ld_be;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R1 ld_ready", ld_ready, !m_head);
      chk("R2 stop_n", stop_n, !e_stop);
      chk("R4 trdy_n", trdy_n, !e_trdy);
      chk("R10 done", done, e_done);
      chk("R9 done_tperr", done_tperr, e_dtp);
      chk("R7 perr_n", perr_n, !e_perr);
      chk("R8 perr_det", perr_det, m_det);
      if (done) done_seen++;
      if (!perr_n) perr_seen++;
      if (!stop_n) stop_seen++;
      if (!trdy_n) trdy_seen++;
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] a, input logic [3:0] c,
                      input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_cmd = c; ld_data = d; ld_be = b;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic give_sts(input logic tp);
    @(negedge clk);
    sts_valid = 1; sts_tperr = tp;
    @(negedge clk);
    sts_valid = 0; sts_tperr = 0;
  endtask

  task automatic attempt(input logic [31:0] a, input logic [3:0] c,
                         input logic [31:0] d, input logic [3:0] b,
                         input bit bad, input bit clr_at_par, input bit b2b);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_cmd = c; req_data = d; req_be = b;
    @(negedge clk);
    req_valid = b2b;
    req_par = (^d) ^ (^b) ^ bad;
    perr_det_clr = clr_at_par;
    @(negedge clk);
    req_valid = 0; req_par = 0; perr_det_clr = 0;
    idle(4);
  endtask

  initial begin
    int d0, p0, s0;
    idle(3);
    started = 1;
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 reset ld_ready", ld_ready, 1'b1);
    chk("R4 reset trdy_n", trdy_n, 1'b1);
    chk("R8 reset perr_det", perr_det, 1'b0);

    // R2 no entry held
    s0 = stop_seen;
    attempt(32'h1000, 4'h7, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    chk_int("R2 retry without entry", stop_seen - s0, 1);

    // R2 entry without status
    load(32'h1000, 4'h7, 32'hA5A5_0001, 4'hF);
    s0 = stop_seen;
    attempt(32'h1000, 4'h7, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    chk_int("R2 retry without status", stop_seen - s0, 1);
    chk("R2 entry kept", ld_ready, 1'b0);

    // R3 single-field mismatches
    give_sts(0);
    s0 = stop_seen;
    attempt(32'h1004, 4'h7, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    attempt(32'h1000, 4'h6, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    attempt(32'h1000, 4'h7, 32'hA5A5_0003, 4'hF, 0, 0, 0);
    attempt(32'h1000, 4'h7, 32'hA5A5_0001, 4'hE, 0, 0, 0);
    chk_int("R3 mismatches retried", stop_seen - s0, 4);

    // R10 clean match completes
    d0 = done_seen;
    attempt(32'h1000, 4'h7, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    chk_int("R10 clean completion", done_seen - d0, 1);
    chk("R10 entry removed", ld_ready, 1'b1);

    // R6 R7 local error, enable on; R3 parity excluded from match
    pe_resp_pri = 1;
    load(32'h2000, 4'h7, 32'h0000_0007, 4'h3);
    give_sts(0);
    d0 = done_seen; p0 = perr_seen; s0 = trdy_seen;
    attempt(32'h2000, 4'h7, 32'h0000_0007, 4'h3, 1, 0, 0);
    chk_int("R3 bad parity still acknowledged", trdy_seen - s0, 1);
    chk_int("R6 no completion on local error", done_seen - d0, 0);
    chk("R6 entry kept", ld_ready, 1'b0);
    chk_int("R7 strobe with enable", perr_seen - p0, 1);
    chk("R5 R8 error flagged", perr_det, 1'b1);
    @(negedge clk); perr_det_clr = 1;
    @(negedge clk); perr_det_clr = 0;
    chk("R8 cleared", perr_det, 1'b0);

    // R7 R8 local error, enable off
    pe_resp_pri = 0;
    p0 = perr_seen;
    attempt(32'h2000, 4'h7, 32'h0000_0007, 4'h3, 1, 0, 0);
    chk_int("R7 no strobe without enable", perr_seen - p0, 0);
    chk("R8 set without enable", perr_det, 1'b1);

    // R8 set wins over simultaneous clear
    attempt(32'h2000, 4'h7, 32'h0000_0007, 4'h3, 1, 1, 0);
    chk("R8 set beats clear", perr_det, 1'b1);

    // R6 clean retry after local error
    d0 = done_seen;
    attempt(32'h2000, 4'h7, 32'h0000_0007, 4'h3, 0, 0, 0);
    chk_int("R6 later clean completion", done_seen - d0, 1);

    // R9 forwarded error, all enable combinations
    for (int k = 0; k < 4; k++) begin
      pe_resp_pri = k[0]; pe_resp_sec = k[1];
      load(32'h3000 + k, 4'h7, 32'h1234_0000 + k, 4'h5);
      give_sts(1);
      d0 = done_seen; p0 = perr_seen;
      attempt(32'h3000 + k, 4'h7, 32'h1234_0000 + k, 4'h5, 0, 0, 0);
      chk_int("R9 forwarded completes", done_seen - d0, 1);
      chk_int("R9 strobe needs both enables", perr_seen - p0, (k == 3) ? 1 : 0);
    end

    // R11 phase during parity wait is retried
    pe_resp_pri = 1; pe_resp_sec = 1;
    load(32'h4000, 4'h7, 32'h0F0F_F0F0, 4'hF);
    give_sts(0);
    s0 = stop_seen; d0 = done_seen;
    attempt(32'h4000, 4'h7, 32'h0F0F_F0F0, 4'hF, 0, 0, 1);
    chk_int("R11 overlapping phase retried", stop_seen - s0, 1);
    chk_int("R11 single completion", done_seen - d0, 1);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule